// File: doc/BRIEF.md
# Dual-Convention Host Transmit Write Port

This block is the host-facing write side of a transmit path. The host presents a 12-bit data value and a one-bit flag that marks the value as a special character rather than plain data. The port turns that bus activity into a single-cycle write strobe with a 13-bit word for the storage stage that follows. The port performs no storage, encoding or serialization.

A static convention input selects how the host bus behaves. In the cell-bus convention several ports share one host bus. The enable and the two status outputs are active low, and the word is taken on the same clock edge that samples the enable. In the cascade convention all three signals are active high, and the write is delayed by one cycle. The word stored is the bus value one clock after the enable was sampled. This suits a controller that requests a write one cycle before its data is ready. Both conventions use the same selection rule. A port becomes selected when its address-match input is true together with an asserted enable. It stays selected while the enable stays asserted, and it drops the selection as soon as the enable is sampled deasserted.

The storage stage reports full and empty to the port as active-high levels. The port shows them to the host at the polarity of the chosen convention. A write that would land while full is reported is dropped.

Top module: `hostport_tx`

## Requirements
- R1: The output word is {special flag, data}: bit 12 holds the special-character flag and bits 11:0 hold the data. In both conventions, `wr_word` after a strobe equals the bus value sampled on the rising edge that produced the strobe.
- R2: With `cascade_mode` = 0, `host_en` = 0 means asserted. `host_full` equals the inverse of `buf_full`, and `host_empty` equals the inverse of `buf_empty`.
- R3: With `cascade_mode` = 1, `host_en` = 1 means asserted. `host_full` equals `buf_full`, and `host_empty` equals `buf_empty`.
- R4: An asserted enable without `addr_match` on an unselected port produces no write and no selection.
- R5: A selected port writes one word on every cycle in which the enable stays asserted, whatever the level of `addr_match`.
- R6: Sampling the enable deasserted deselects the port. A later write then needs `addr_match` again.
- R7: With `cascade_mode` = 0, `wr_strobe` is high in the cycle right after the rising edge that samples the write condition.
- R8: With `cascade_mode` = 1, `wr_strobe` is high in the cycle after the edge following the one that sampled the write condition. The word is taken on that later edge.
- R9: A write whose capture edge sees `buf_full` = 1 produces no strobe. The selection is not affected.
- R10: A synchronous reset (`rst` = 1) clears the strobe, the selection and any delayed write that is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cascade_mode | input | 1 | Static convention select: 0 cell-bus, 1 cascade |
| addr_match | input | 1 | Address match for this port, active high |
| host_en | input | 1 | Host write enable, polarity set by convention |
| host_data | input | 12 | Host data bits |
| host_sc | input | 1 | Special-character flag (1) or data (0) |
| buf_full | input | 1 | Downstream full, active high |
| buf_empty | input | 1 | Downstream empty, active high |
| host_full | output | 1 | Full flag to host at convention polarity |
| host_empty | output | 1 | Empty flag to host at convention polarity |
| wr_strobe | output | 1 | One-cycle write strobe to storage |
| wr_word | output | 13 | Word written: {special flag, data} |

## Verification
The hardest case to reach is a delayed cascade write that is already waiting when something cuts in. That can be a reset, a full indication on the capture edge, or the enable dropping on the very cycle the word is taken. To reach it, the stimulus table selects the port in cascade mode and then changes the bus, the enable or the full level on the following cycle. A directed sequence sets up a waiting write, applies reset on the next edge, and then shows that neither the strobe nor the selection survives.

// File: rtl/hostport_pkg.sv
package hostport_pkg;

    localparam int DATA_W = 12;
    localparam int WORD_W = DATA_W + 1;
    localparam int NFLAGS = 2;

    typedef enum logic {
        CONV_CELLBUS = 1'b0,
        CONV_CASCADE = 1'b1
    } conv_e;

    typedef struct packed {
        logic              sc;
        logic [DATA_W-1:0] data;
    } hword_t;

    // converts between an active-high level and the pin level of a convention
    function automatic logic pin_level(input logic lvl, input conv_e conv);
        return (conv == CONV_CASCADE) ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/hp_select.sv
module hp_select
    import hostport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  conv_e conv,
    input  logic  addr_match,
    input  logic  en_pin,
    output logic  wr_go
);
    logic en_act;
    logic sel_q;

    assign en_act = pin_level(en_pin, conv);
    assign wr_go  = en_act && (sel_q || addr_match);

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= wr_go;
    end
endmodule

// File: rtl/hp_capture.sv
module hp_capture
    import hostport_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  conv_e  conv,
    input  logic   wr_go,
    input  hword_t bus,
    input  logic   buf_full,
    output logic   strobe,
    output hword_t word
);
    logic pend_q;
    logic take_now;

    assign take_now = (conv == CONV_CASCADE) ? pend_q : wr_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            strobe <= 1'b0;
        end else begin
            pend_q <= (conv == CONV_CASCADE) && wr_go;
            strobe <= take_now && !buf_full;
        end
    end

    always_ff @(posedge clk) begin
        if (take_now && !buf_full) word <= bus;
    end
endmodule

// File: rtl/hp_flags.sv
module hp_flags
    import hostport_pkg::*;
(
    input  conv_e             conv,
    input  logic [NFLAGS-1:0] lvl,
    output logic [NFLAGS-1:0] pin
);
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        assign pin[i] = pin_level(lvl[i], conv);
    end
endmodule

// File: rtl/hostport_tx.sv
module hostport_tx
    import hostport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cascade_mode,
    input  logic              addr_match,
    input  logic              host_en,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_sc,
    input  logic              buf_full,
    input  logic              buf_empty,
    output logic              host_full,
    output logic              host_empty,
    output logic              wr_strobe,
    output logic [WORD_W-1:0] wr_word
);
    conv_e             conv;
    logic              go_w;
    hword_t            bus_w;
    hword_t            word_w;
    logic [NFLAGS-1:0] flag_lvl;
    logic [NFLAGS-1:0] flag_pin;

    assign conv     = conv_e'(cascade_mode);
    assign bus_w    = '{sc: host_sc, data: host_data};
    assign flag_lvl = {buf_empty, buf_full};

    hp_select u_sel (
        .clk        (clk),
        .rst        (rst),
        .conv       (conv),
        .addr_match (addr_match),
        .en_pin     (host_en),
        .wr_go      (go_w)
    );

    hp_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .conv     (conv),
        .wr_go    (go_w),
        .bus      (bus_w),
        .buf_full (buf_full),
        .strobe   (wr_strobe),
        .word     (word_w)
    );

    hp_flags u_flg (
        .conv (conv),
        .lvl  (flag_lvl),
        .pin  (flag_pin)
    );

    assign wr_word    = word_w;
    assign host_full  = flag_pin[0];
    assign host_empty = flag_pin[1];
endmodule

// File: rtl/hostport_tx_chk.sv
module hostport_tx_chk
    import hostport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cascade_mode,
    input logic              host_en,
    input logic [DATA_W-1:0] host_data,
    input logic              host_sc,
    input logic              buf_full,
    input logic              wr_go,
    input logic              wr_strobe,
    input logic [WORD_W-1:0] wr_word
);
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> !$past(buf_full));

    p_word_align_r1: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (wr_word == $past({host_sc, host_data})));

    p_lowactive_en_r2: assert property (@(posedge clk) disable iff (rst)
        (!cascade_mode && $past(!cascade_mode) && wr_strobe) |-> !$past(host_en));

    p_delayed_write_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(cascade_mode) && $past(cascade_mode, 2) && $past(wr_go, 2) &&
         !$past(buf_full) && !$past(rst) && !$past(rst, 2)) |-> wr_strobe);

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wr_strobe);
endmodule

bind hostport_tx hostport_tx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cascade_mode (cascade_mode),
    .host_en      (host_en),
    .host_data    (host_data),
    .host_sc      (host_sc),
    .buf_full     (buf_full),
    .wr_go        (go_w),
    .wr_strobe    (wr_strobe),
    .wr_word      (wr_word)
);

// File: tb/tb_hostport_tx.sv
module tb_hostport_tx;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cascade_mode = 1'b0;
    logic        addr_match = 1'b0;
    logic        host_en = 1'b1;
    logic [11:0] host_data = '0;
    logic        host_sc = 1'b0;
    logic        buf_full = 1'b0;
    logic        buf_empty = 1'b0;
    logic        host_full, host_empty, wr_strobe;
    logic [12:0] wr_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostport_tx dut (
        .clk(clk), .rst(rst), .cascade_mode(cascade_mode), .addr_match(addr_match),
        .host_en(host_en), .host_data(host_data), .host_sc(host_sc),
        .buf_full(buf_full), .buf_empty(buf_empty), .host_full(host_full),
        .host_empty(host_empty), .wr_strobe(wr_strobe), .wr_word(wr_word)
    );

    // layout: mode, addr, en, sc, data[11:0], full, exp_strobe, exp_word[12:0]
    localparam logic [30:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 12'h0A0, 1'b0, 1'b0, 13'h0000}, // R4 enable without match
        {1'b0, 1'b1, 1'b0, 1'b1, 12'h111, 1'b0, 1'b1, 13'h1111}, // R7 select and write
        {1'b0, 1'b0, 1'b0, 1'b0, 12'h222, 1'b0, 1'b1, 13'h0222}, // R5 stays selected
        {1'b0, 1'b0, 1'b1, 1'b0, 12'h333, 1'b0, 1'b0, 13'h0000}, // R2 high pin deasserts
        {1'b0, 1'b0, 1'b0, 1'b0, 12'h444, 1'b0, 1'b0, 13'h0000}, // R6 needs match again
        {1'b0, 1'b1, 1'b0, 1'b0, 12'h555, 1'b1, 1'b0, 13'h0000}, // R9 full drops write
        {1'b0, 1'b0, 1'b0, 1'b0, 12'h666, 1'b0, 1'b1, 13'h0666}, // R9 selection kept
        {1'b1, 1'b0, 1'b0, 1'b0, 12'h777, 1'b0, 1'b0, 13'h0000}, // R3 low pin deasserts
        {1'b1, 1'b1, 1'b1, 1'b0, 12'h0AA, 1'b0, 1'b0, 13'h0000}, // R8 no same-cycle write
        {1'b1, 1'b0, 1'b0, 1'b1, 12'h0BB, 1'b0, 1'b1, 13'h10BB}, // R8 delayed word
        {1'b1, 1'b0, 1'b1, 1'b0, 12'h0CC, 1'b0, 1'b0, 13'h0000}, // R6 deselected
        {1'b1, 1'b1, 1'b1, 1'b0, 12'h0DD, 1'b0, 1'b0, 13'h0000}, // R8 select again
        {1'b1, 1'b0, 1'b1, 1'b0, 12'h0EE, 1'b0, 1'b1, 13'h00EE}, // R5 delayed word
        {1'b1, 1'b0, 1'b0, 1'b0, 12'h0FF, 1'b1, 1'b0, 13'h0000}, // R9 full at capture
        {1'b1, 1'b0, 1'b0, 1'b0, 12'h123, 1'b0, 1'b0, 13'h0000}  // R6 nothing waiting
    };

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 reset strobe", {12'd0, wr_strobe}, 13'd0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            cascade_mode = VEC[i][30];
            addr_match   = VEC[i][29];
            host_en      = VEC[i][28];
            host_sc      = VEC[i][27];
            host_data    = VEC[i][26:15];
            buf_full     = VEC[i][14];
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R7/R8 row %0d strobe", i), {12'd0, wr_strobe}, {12'd0, VEC[i][13]});
            if (VEC[i][13])
                check($sformatf("R1 row %0d word", i), wr_word, VEC[i][12:0]);
        end

        // R10: reset wipes a waiting delayed write and the selection
        buf_full = 1'b0;
        cascade_mode = 1'b1; addr_match = 1'b1; host_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b1; addr_match = 1'b0; host_en = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10 waiting write cleared", {12'd0, wr_strobe}, 13'd0);
        rst = 1'b0; host_en = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 after reset", {12'd0, wr_strobe}, 13'd0);
        @(posedge clk); @(negedge clk);
        check("R10 selection cleared", {12'd0, wr_strobe}, 13'd0);

        // R2 / R3: flag polarity
        cascade_mode = 1'b0; buf_full = 1'b1; buf_empty = 1'b0; #1;
        check("R2 full pin", {12'd0, host_full}, 13'd0);
        check("R2 empty pin", {12'd0, host_empty}, 13'd1);
        cascade_mode = 1'b1; #1;
        check("R3 full pin", {12'd0, host_full}, 13'd1);
        check("R3 empty pin", {12'd0, host_empty}, 13'd0);

        finish_run();
    end
endmodule